// File: doc/BRIEF.md
# Set/Clear Register GPIO Port

This block is a general-purpose I/O port of up to 32 lines attached to a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. Software never writes the output-level or direction state as a whole word. Each of those states, and the per-line debounce enable, has two write-only registers. One sets the bits that are written as 1 and the other clears them. A driver can therefore change one line without a read-modify-write sequence that could race with another agent.

Each pad input passes through a two-flop synchroniser. Each line can also be routed through a debounce filter that counts strobes on a debounce-tick input. The filtered level of every line is readable as one word. The pad output enable of a line follows its direction bit directly.

Top module: `gpio_sc_port`

## Requirements
- R1: A write to address 0x00 drives pad_out high for every line whose write-data bit is 1. Lines whose bit is 0 keep their level. The change is visible from the cycle after the write.
- R2: A write to address 0x04 drives pad_out low for every line whose write-data bit is 1. Lines whose bit is 0 keep their level.
- R3: A write to address 0x10 makes the selected lines outputs (pad_oe bit = 1). A write to address 0x14 makes the selected lines inputs (pad_oe bit = 0). Unselected lines keep their direction.
- R4: A read of address 0x18 returns the direction of all lines, where 1 means output, with line n at bit n.
- R5: A read of address 0x80 returns the line input levels, with line n at bit n. With debounce off, a pad change is returned after exactly two rising clock edges.
- R6: A write to address 0x60 enables debounce on the selected lines, and a write to address 0x64 disables it. With debounce on and the tick held high, a pad change is returned after 2 + DBNC_TICKS rising edges. Other lines keep their plain two-edge latency.
- R7: With debounce on, the filtered level advances only on cycles where dbnc_tick is 1. A pad pulse shorter than DBNC_TICKS ticks never reaches the read value.
- R8: Write-data bits at positions NLINES and above have no effect, and those positions read as 0 (NLINES defaults to 24).
- R9: After reset, all lines are inputs, pad_out is 0, and debounce is off on every line.
- R10: A read of any of the six write-only set/clear addresses, or of an unmapped address, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| dbnc_tick | input | 1 | Debounce counting strobe |
| pad_in | input | NLINES | Pad input levels |
| pad_out | output | NLINES | Pad output levels |
| pad_oe | output | NLINES | Pad output enables |

## Verification
Random words are written to the six set/clear addresses in random order and compared against a bench model. Masks with both ones and zeros show that only the written-one lines move and that set and clear are not swapped. Directed pad steps are sampled one edge before and exactly at the expected edge. This pins the two-edge synchroniser latency and the 2 + DBNC_TICKS debounce latency. A case that mixes a debounced line with a plain line shows that the enable is per line. Short glitches and a held-low tick show that the filter rejects pulses and counts only ticks.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam logic [7:0] OFF_DOUT_SET = 8'h00;
  localparam logic [7:0] OFF_DOUT_CLR = 8'h04;
  localparam logic [7:0] OFF_DIR_SET  = 8'h10;
  localparam logic [7:0] OFF_DIR_CLR  = 8'h14;
  localparam logic [7:0] OFF_DIR_STAT = 8'h18;
  localparam logic [7:0] OFF_DBN_SET  = 8'h60;
  localparam logic [7:0] OFF_DBN_CLR  = 8'h64;
  localparam logic [7:0] OFF_EXT_PORT = 8'h80;

  // next state of a set/clear register; clear wins if both are presented
  function automatic logic [31:0] sc_next(input logic [31:0] cur,
                                          input logic [31:0] set_m,
                                          input logic [31:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction
endpackage

// File: rtl/gpio_sc_setclr_reg.sv
module gpio_sc_setclr_reg #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] q
);
  import gpio_sc_pkg::*;

  logic [31:0] set_w, clr_w, cur_w, nxt_w;
  always_comb begin
    set_w = '0;
    clr_w = '0;
    cur_w = '0;
    if (set_en) set_w[WIDTH-1:0] = mask;
    if (clr_en) clr_w[WIDTH-1:0] = mask;
    cur_w[WIDTH-1:0] = q;
    nxt_w = sc_next(cur_w, set_w, clr_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt_w[WIDTH-1:0];
  end

  assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> ((q & $past(mask)) == $past(mask)));
  assert_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((q & $past(mask)) == '0));
  assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en || clr_en) |=> (((q ^ $past(q)) & ~$past(mask)) == '0));
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en || clr_en) |=> $stable(q));
endmodule

// File: rtl/gpio_sc_in_filter.sv
module gpio_sc_in_filter #(
  parameter int NLINES     = 24,
  parameter int DBNC_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pad_in,
  input  logic [NLINES-1:0] dbnc_en,
  input  logic              tick,
  output logic [NLINES-1:0] line_val
);
  localparam int CNT_W = (DBNC_TICKS < 2) ? 1 : $clog2(DBNC_TICKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DBNC_TICKS - 1);

  logic [NLINES-1:0] sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic             stable_q;
    logic [CNT_W-1:0] cnt_q;
    logic             differs;
    logic             accept;

    assign differs = sync2_q[i] != stable_q;
    assign accept  = differs && tick && (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stable_q <= 1'b0;
        cnt_q    <= '0;
      end else if (!dbnc_en[i] || !differs) begin
        stable_q <= dbnc_en[i] ? stable_q : sync2_q[i];
        cnt_q    <= '0;
      end else if (tick) begin
        if (accept) begin
          stable_q <= sync2_q[i];
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign line_val[i] = dbnc_en[i] ? stable_q : sync2_q[i];

    assert_tick_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dbnc_en[i] && !tick) |=> $stable(stable_q));
    assert_agree_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dbnc_en[i] && !differs) |=> $stable(stable_q));
  end
endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port #(
  parameter int NLINES     = 24,
  parameter int DBNC_TICKS = 4,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dbnc_tick,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe
);
  import gpio_sc_pkg::*;

  logic [7:0]        addr8;
  logic [NLINES-1:0] wmask, dir_q, dben_q, ext_val;
  logic              wr_dset, wr_dclr, wr_rset, wr_rclr, wr_bset, wr_bclr;

  assign addr8 = 8'(bus_addr);
  assign wmask = bus_wdata[NLINES-1:0];

  assign wr_dset = bus_wr && addr8 == OFF_DOUT_SET;
  assign wr_dclr = bus_wr && addr8 == OFF_DOUT_CLR;
  assign wr_rset = bus_wr && addr8 == OFF_DIR_SET;
  assign wr_rclr = bus_wr && addr8 == OFF_DIR_CLR;
  assign wr_bset = bus_wr && addr8 == OFF_DBN_SET;
  assign wr_bclr = bus_wr && addr8 == OFF_DBN_CLR;

  gpio_sc_setclr_reg #(.WIDTH(NLINES)) u_dout (
    .clk(clk), .rst_n(rst_n), .set_en(wr_dset), .clr_en(wr_dclr),
    .mask(wmask), .q(pad_out));
  gpio_sc_setclr_reg #(.WIDTH(NLINES)) u_dir (
    .clk(clk), .rst_n(rst_n), .set_en(wr_rset), .clr_en(wr_rclr),
    .mask(wmask), .q(dir_q));
  gpio_sc_setclr_reg #(.WIDTH(NLINES)) u_dben (
    .clk(clk), .rst_n(rst_n), .set_en(wr_bset), .clr_en(wr_bclr),
    .mask(wmask), .q(dben_q));

  gpio_sc_in_filter #(.NLINES(NLINES), .DBNC_TICKS(DBNC_TICKS)) u_filt (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .dbnc_en(dben_q),
    .tick(dbnc_tick), .line_val(ext_val));

  assign pad_oe = dir_q;

  always_comb begin
    bus_rdata = '0;
    if (addr8 == OFF_DIR_STAT)      bus_rdata[NLINES-1:0] = dir_q;
    else if (addr8 == OFF_EXT_PORT) bus_rdata[NLINES-1:0] = ext_val;
  end

  assert_wo_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr8 != OFF_DIR_STAT && addr8 != OFF_EXT_PORT) |-> (bus_rdata == '0));
  assert_oe_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_rset || wr_rclr) |=> $stable(pad_oe));
  if (NLINES < 32) begin : g_hi
    assert_hi_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[31:NLINES] == '0);
  end
endmodule

// File: tb/gpio_sc_port_tb.sv
module gpio_sc_port_tb_top;
  localparam int NL = 24;
  localparam int DT = 4;
  localparam logic [31:0] LMASK = (32'h1 << NL) - 1;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = 8'hfc;
  logic        wr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        tick = 1;
  logic [NL-1:0] pin = '0;
  logic [NL-1:0] pout, poe;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_dout = 0, m_dir = 0;

  always #5 clk = ~clk;

  gpio_sc_port #(.NLINES(NL), .DBNC_TICKS(DT), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .dbnc_tick(tick), .pad_in(pin), .pad_out(pout), .pad_oe(poe));

  function automatic logic [31:0] f_set(input logic [31:0] o, input logic [31:0] m);
    return o | (m & LMASK);
  endfunction
  function automatic logic [31:0] f_clr(input logic [31:0] o, input logic [31:0] m);
    return o & ~(m & LMASK);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr = 1; wdata = d;
    @(negedge clk); wr = 0; addr = 8'hfc;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    check("R9 pad_out", 32'(pout), 0);
    check("R9 pad_oe", 32'(poe), 0);
    rd_reg(8'h18, r); check("R9 dir status", r, 0);
    // R1 / R2 directed
    wr_reg(8'h00, 32'h0000_00a5); m_dout = 32'ha5;
    check("R1 set", 32'(pout), m_dout);
    wr_reg(8'h04, 32'h0000_0021); m_dout = 32'h84;
    check("R2 clear", 32'(pout), m_dout);
    // R8 high bits ignored
    wr_reg(8'h00, 32'hff00_0000);
    check("R8 set high bits", 32'(pout), m_dout);
    wr_reg(8'h10, 32'hffff_ffff); m_dir = LMASK;
    rd_reg(8'h18, r); check("R8 status high bits zero", r, LMASK);
    wr_reg(8'h14, 32'hffff_ffff); m_dir = 0;
    check("R3 all inputs", 32'(poe), 0);
    // R10 reads of write-only and unmapped
    foreach (r[i]) ; // no-op
    for (int k = 0; k < 7; k++) begin
      logic [7:0] a;
      a = (k == 0) ? 8'h00 : (k == 1) ? 8'h04 : (k == 2) ? 8'h10 : (k == 3) ? 8'h14 :
          (k == 4) ? 8'h60 : (k == 5) ? 8'h64 : 8'h40;
      rd_reg(a, r); check("R10 write-only reads zero", r, 0);
    end
    // random set/clear traffic: R1 R2 R3 R4
    for (int it = 0; it < 300; it++) begin
      int sel; logic [31:0] d;
      sel = $urandom % 6; d = $urandom;
      case (sel)
        0: begin wr_reg(8'h00, d); m_dout = f_set(m_dout, d); end
        1: begin wr_reg(8'h04, d); m_dout = f_clr(m_dout, d); end
        2: begin wr_reg(8'h10, d); m_dir = f_set(m_dir, d); end
        3: begin wr_reg(8'h14, d); m_dir = f_clr(m_dir, d); end
        4: wr_reg(8'h60, d & ~LMASK);  // R8: only ignored bits, debounce stays off
        default: wr_reg(8'h64, d);
      endcase
      check("R1/R2 pad_out", 32'(pout), m_dout);
      check("R3 pad_oe", 32'(poe), m_dir);
      rd_reg(8'h18, r); check("R4 dir status", r, m_dir);
    end
    // R5 plain latency
    wr_reg(8'h64, LMASK);
    @(negedge clk); addr = 8'h80; pin = 24'h00f00f;
    @(negedge clk); check("R5 one edge old", rdata, 0);
    @(negedge clk); check("R5 two edges new", rdata, 32'h00f00f);
    pin = '0; repeat (3) @(negedge clk);
    check("R5 back low", rdata, 0);
    // R6 debounce latency, line 0 debounced, line 1 plain
    wr_reg(8'h60, 32'h1);
    addr = 8'h80;
    @(negedge clk); pin = 24'h3;
    @(negedge clk); @(negedge clk);
    check("R6 plain line vs debounced", rdata, 32'h2);
    repeat (3) @(negedge clk);
    check("R6 debounce five edges old", rdata, 32'h2);
    @(negedge clk); check("R6 debounce six edges new", rdata, 32'h3);
    // R7 glitch rejected
    pin = 24'h2; @(negedge clk); @(negedge clk); pin = 24'h3;
    repeat (20) @(negedge clk);
    check("R7 glitch rejected", rdata, 32'h3);
    // R7 no tick no advance
    tick = 0; pin = 24'h2;
    repeat (30) @(negedge clk);
    check("R7 tick low holds", rdata, 32'h3);
    tick = 1; repeat (DT + 1) @(negedge clk);
    check("R7 tick resumes", rdata, 32'h2);
    // R6 disable returns line to plain path
    wr_reg(8'h64, 32'h1); addr = 8'h80;
    @(negedge clk); pin = 24'h1;
    @(negedge clk); @(negedge clk);
    check("R6 disabled plain latency", rdata, 32'h1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule